// File: doc/BRIEF.md
# DDR2 Write Turnaround Guard

The guard sits in the command path of a DDR2 memory controller, after the command picker and before the command bus. It watches every proposed command. For each precharge or read it decides whether the command may go out in the current cycle or must wait. It enforces two minimum gaps that follow a write. One is write-to-precharge, counted per bank. The other is write-to-read, counted per rank. Each gap is the sum of CAS latency minus one, half the burst length, and the write recovery time (tWR) or the write-to-read delay (tWTR). Software works the sum out and programs it as a 4-bit clock count.

Both counts arrive as the top byte of the controller's timing register. The guard holds its own copy of that byte. Every accepted write restarts the precharge timer of its bank and the read timer of its rank. Grant and stall are combinational decisions on the current command. A code outside a field's legal range sets a sticky error flag, and from then on that field runs at its largest legal count.

Top module: `ddr2_wturn_guard`

## Requirements
- R1: Command codes on `cmd_op` are 00 idle, 01 write, 10 read and 11 precharge. A valid write is always granted and never stalled. An idle command, or any cycle with `cmd_valid` low, gives neither grant nor stall.
- R2: A precharge to a rank/bank pair in cycle t+k, after a write to the same pair in cycle t, is stalled while k is below the effective precharge gap. It is granted once k equals or exceeds that gap. With no write since reset, it is granted at once.
- R3: A read to a rank in cycle t+k, after a write to that rank in cycle t, is stalled while k is below the effective read gap. It is granted once k equals or exceeds that gap. With no write since reset, it is granted at once.
- R4: A write affects only the precharge timer of its own rank/bank pair and the read timer of its own rank. Other banks and ranks keep their state.
- R5: A write to a pair or rank whose gap is still counting restarts the count from the full gap, measured from the newer write.
- R6: `cfg_hi[7:4]` is the precharge gap code and `cfg_hi[3:0]` the read gap code. Both are loaded on `cfg_wr`, take effect for writes in later cycles, and reset to 0xB and 0x9.
- R7: Loading a precharge code of 0x0 to 0x3, or a read code of 0x0 to 0x5 or 0xD to 0xF, sets `cfg_err` from the next cycle. Only reset clears it. Codes 0x4 to 0xF and 0x6 to 0xC are legal.
- R8: Once a field has received a reserved code, its effective gap is 15 for precharge and 12 for read, whatever codes are loaded later.
- R9: `cmd_stall` is high exactly when a valid read or precharge is not granted. Grant and stall are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the timing byte |
| cfg_hi | input | 8 | Timing byte: [7:4] precharge gap code, [3:0] read gap code |
| cmd_valid | input | 1 | A command is proposed this cycle |
| cmd_op | input | 2 | Command code (see R1) |
| cmd_rank | input | RW | Target rank |
| cmd_bank | input | BW | Target bank within the rank |
| cmd_grant | output | 1 | Command may issue this cycle |
| cmd_stall | output | 1 | Read or precharge must wait |
| cfg_err | output | 1 | Sticky reserved-code flag |

## Verification
The bound checker runs on every cycle. It checks that writes are always granted, that grant and stall never coincide, and that stall appears only on a valid read or precharge. It checks that a same-bank precharge or same-rank read in the cycle right after a write is held back. It also checks that the error flag never drops and follows any reserved load, and that a faulted field sits at its ceiling gap. The exact cycle where a stall turns into a grant needs an independent timing model, so only the bench scenarios show it. The same holds for a second write restarting its timer, for isolation between banks and ranks, and for later legal loads leaving a faulted field at its ceiling.

// File: rtl/wturn_pkg.sv
package wturn_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_PRECHG = 2'b11
  } wturn_op_e;

  localparam int FW = 4;
  localparam logic [FW-1:0] WTP_CEIL = 4'hF;
  localparam logic [FW-1:0] WTR_CEIL = 4'hC;

  // precharge gap code legal when 4 or more
  function automatic logic wtp_code_ok(input logic [FW-1:0] code);
    return code >= 4'h4;
  endfunction

  // read gap code legal in 6..12
  function automatic logic wtr_code_ok(input logic [FW-1:0] code);
    return (code >= 4'h6) && (code <= 4'hC);
  endfunction

  function automatic logic [FW-1:0] pick_gap(input logic [FW-1:0] code,
                                             input logic err,
                                             input logic [FW-1:0] ceil);
    return err ? ceil : code;
  endfunction

  // timer loaded with gap-1 reaches zero exactly gap cycles after the write
  function automatic logic [FW-1:0] reload_of(input logic [FW-1:0] gap);
    return gap - 4'd1;
  endfunction

endpackage

// File: rtl/wturn_cfg.sv
module wturn_cfg
  import wturn_pkg::*;
#(
  parameter logic [FW-1:0] WTP_RST = 4'hB,
  parameter logic [FW-1:0] WTR_RST = 4'h9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2*FW-1:0] cfg_hi,
  output logic [FW-1:0] gap_wtp,
  output logic [FW-1:0] gap_wtr,
  output logic          err_wtp,
  output logic          err_wtr
);

  logic [FW-1:0] wtp_q, wtr_q;
  wire  [FW-1:0] wtp_in = cfg_hi[2*FW-1:FW];
  wire  [FW-1:0] wtr_in = cfg_hi[FW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wtp_q   <= WTP_RST;
      wtr_q   <= WTR_RST;
      err_wtp <= 1'b0;
      err_wtr <= 1'b0;
    end else if (cfg_wr) begin
      wtp_q <= wtp_in;
      wtr_q <= wtr_in;
      if (!wtp_code_ok(wtp_in)) err_wtp <= 1'b1;
      if (!wtr_code_ok(wtr_in)) err_wtr <= 1'b1;
    end
  end

  assign gap_wtp = pick_gap(wtp_q, err_wtp, WTP_CEIL);
  assign gap_wtr = pick_gap(wtr_q, err_wtr, WTR_CEIL);

endmodule

// File: rtl/wturn_gap_timer.sv
module wturn_gap_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          open
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign open = (cnt == '0);

endmodule

// File: rtl/ddr2_wturn_guard.sv
module ddr2_wturn_guard
  import wturn_pkg::*;
#(
  parameter int RANKS = 2,
  parameter int BANKS = 4,
  parameter logic [3:0] WTP_RST = 4'hB,
  parameter logic [3:0] WTR_RST = 4'h9,
  localparam int RW = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_hi,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_rank,
  input  logic [BW-1:0] cmd_bank,
  output logic          cmd_grant,
  output logic          cmd_stall,
  output logic          cfg_err
);

  localparam int NB = RANKS * BANKS;

  wturn_op_e     op_e;
  logic [FW-1:0] gap_wtp, gap_wtr;
  logic          err_wtp, err_wtr;
  logic          wr_fire;
  logic [NB-1:0]    bank_hit, pc_open;
  logic [RANKS-1:0] rank_hit, rd_open;
  logic          pc_ok, rd_ok;

  assign op_e    = wturn_op_e'(cmd_op);
  assign wr_fire = cmd_valid && (op_e == OP_WRITE);

  wturn_cfg #(.WTP_RST(WTP_RST), .WTR_RST(WTR_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_hi  (cfg_hi),
    .gap_wtp (gap_wtp),
    .gap_wtr (gap_wtr),
    .err_wtp (err_wtp),
    .err_wtr (err_wtr)
  );

  // one write-to-precharge timer per rank/bank pair
  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    localparam int RI = gi / BANKS;
    localparam int BI = gi % BANKS;
    assign bank_hit[gi] = (cmd_rank == RW'(RI)) && (cmd_bank == BW'(BI));
    wturn_gap_timer #(.CW(FW)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_fire && bank_hit[gi]),
      .load_val (reload_of(gap_wtp)),
      .open     (pc_open[gi])
    );
  end

  // one write-to-read timer per rank
  for (genvar gr = 0; gr < RANKS; gr++) begin : g_rank
    assign rank_hit[gr] = (cmd_rank == RW'(gr));
    wturn_gap_timer #(.CW(FW)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_fire && rank_hit[gr]),
      .load_val (reload_of(gap_wtr)),
      .open     (rd_open[gr])
    );
  end

  assign pc_ok = |(bank_hit & pc_open);
  assign rd_ok = |(rank_hit & rd_open);

  always_comb begin
    cmd_grant = 1'b0;
    case (op_e)
      OP_WRITE:  cmd_grant = cmd_valid;
      OP_READ:   cmd_grant = cmd_valid && rd_ok;
      OP_PRECHG: cmd_grant = cmd_valid && pc_ok;
      default:   cmd_grant = 1'b0;
    endcase
  end

  assign cmd_stall = cmd_valid && ((op_e == OP_READ) || (op_e == OP_PRECHG)) && !cmd_grant;
  assign cfg_err   = err_wtp || err_wtr;

endmodule

// File: rtl/wturn_guard_chk.sv
module wturn_guard_chk #(
  parameter int RW = 1,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [7:0]    cfg_hi,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [RW-1:0] cmd_rank,
  input logic [BW-1:0] cmd_bank,
  input logic          cmd_grant,
  input logic          cmd_stall,
  input logic          cfg_err,
  input logic          err_wtp,
  input logic          err_wtr,
  input logic [3:0]    gap_wtp,
  input logic [3:0]    gap_wtr,
  input logic          wr_fire
);

  logic          past_ok, prev_wr;
  logic [RW-1:0] prev_rank;
  logic [BW-1:0] prev_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok   <= 1'b0;
      prev_wr   <= 1'b0;
      prev_rank <= '0;
      prev_bank <= '0;
    end else begin
      past_ok   <= 1'b1;
      prev_wr   <= wr_fire;
      prev_rank <= cmd_rank;
      prev_bank <= cmd_bank;
    end
  end

  wire is_wr = cmd_valid && (cmd_op == 2'b01);
  wire is_rd = cmd_valid && (cmd_op == 2'b10);
  wire is_pc = cmd_valid && (cmd_op == 2'b11);
  wire rsvd_p = cfg_hi[7:4] < 4'd4;
  wire rsvd_r = (cfg_hi[3:0] < 4'd6) || (cfg_hi[3:0] > 4'd12);

  AST_WRITE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n) is_wr |-> cmd_grant && !cmd_stall); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(is_rd || is_pc || is_wr) |-> !cmd_grant && !cmd_stall); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_grant && cmd_stall)); // R9
  AST_STALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) cmd_stall |-> (is_rd || is_pc)); // R9
  AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && prev_wr && is_pc && prev_rank == cmd_rank && prev_bank == cmd_bank |-> cmd_stall); // R2
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && prev_wr && is_rd && prev_rank == cmd_rank |-> cmd_stall); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err); // R7
  AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr && (rsvd_p || rsvd_r) |=> cfg_err); // R7
  AST_CEIL_WTP: assert property (@(posedge clk) disable iff (!rst_n) err_wtp |-> gap_wtp == 4'hF); // R8
  AST_CEIL_WTR: assert property (@(posedge clk) disable iff (!rst_n) err_wtr |-> gap_wtr == 4'hC); // R8

endmodule

bind ddr2_wturn_guard wturn_guard_chk #(.RW(RW), .BW(BW)) u_chk (.*);

// File: tb/sim_ddr2_wturn_guard.sv
`timescale 1ns/1ps
module sim_ddr2_wturn_guard;

  localparam int RANKS = 2;
  localparam int BANKS = 4;
  localparam int NB    = RANKS * BANKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_hi = 8'h00;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [0:0] cmd_rank = '0;
  logic [1:0] cmd_bank = '0;
  logic cmd_grant, cmd_stall, cfg_err;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr2_wturn_guard #(.RANKS(RANKS), .BANKS(BANKS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hi(cfg_hi),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
    .cmd_grant(cmd_grant), .cmd_stall(cmd_stall), .cfg_err(cfg_err)
  );

  // bench model: earliest cycle each timer allows its command
  int pc_dl [NB];
  int rd_dl [RANKS];
  logic [3:0] m_wtp, m_wtr;
  bit e_p, e_r;

  function automatic int eff_p();
    return e_p ? 15 : int'(m_wtp);
  endfunction
  function automatic int eff_r();
    return e_r ? 12 : int'(m_wtr);
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    foreach (pc_dl[i]) pc_dl[i] = 0;
    foreach (rd_dl[i]) rd_dl[i] = 0;
    m_wtp = 4'hB; m_wtr = 4'h9; e_p = 0; e_r = 0; cyc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cfg_wr = 1'b0;
    @(negedge clk); @(negedge clk);
    #2;
    check(cmd_grant == 1'b0 && cmd_stall == 1'b0, "R1", "outputs in reset", {cmd_grant, cmd_stall}, 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  // one cycle: drive at negedge, sample 2 ns later, then advance the model
  task automatic step(input logic [1:0] op, input int r, input int b, input bit cw,
                      input logic [7:0] cv, input string tag, output bit got);
    bit exp_g, exp_s;
    int idx;
    @(negedge clk);
    cmd_valid = (op != 2'b00);
    cmd_op = op; cmd_rank = r[0:0]; cmd_bank = b[1:0];
    cfg_wr = cw; cfg_hi = cv;
    idx = r * BANKS + b;
    #2;
    case (op)
      2'b01:   exp_g = 1'b1;
      2'b10:   exp_g = (cyc >= rd_dl[r]);
      2'b11:   exp_g = (cyc >= pc_dl[idx]);
      default: exp_g = 1'b0;
    endcase
    exp_s = (op[1] == 1'b1) && !exp_g;
    check(cmd_grant == exp_g && cmd_stall == exp_s, tag, "grant/stall",
          {cmd_grant, cmd_stall}, {exp_g, exp_s});
    check(cfg_err == (e_p || e_r), "R7", "cfg_err", cfg_err, e_p || e_r);
    got = cmd_grant;
    if (op == 2'b01) begin
      pc_dl[idx] = cyc + eff_p();
      rd_dl[r]   = cyc + eff_r();
    end
    if (cw) begin
      m_wtp = cv[7:4]; m_wtr = cv[3:0];
      if (cv[7:4] < 4) e_p = 1;
      if (cv[3:0] < 6 || cv[3:0] > 12) e_r = 1;
    end
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    bit g;
    for (int i = 0; i < n; i++) step(2'b00, 0, 0, 1'b0, 8'h00, tag, g);
  endtask

  task automatic load_cfg(input logic [7:0] v, input string tag);
    bit g;
    step(2'b00, 0, 0, 1'b1, v, tag, g);
  endtask

  task automatic cmd(input logic [1:0] op, input int r, input int b, input string tag);
    bit g;
    step(op, r, b, 1'b0, 8'h00, tag, g);
  endtask

  // vector: {op[1:0], rank, bank[1:0], idle_before[3:0], expected grant}
  localparam logic [9:0] VEC [15] = '{
    {2'd1, 1'b0, 2'd0, 4'd0, 1'b1},  // write r0 b0
    {2'd2, 1'b0, 2'd0, 4'd0, 1'b0},  // read r0, 1 clock later
    {2'd3, 1'b0, 2'd0, 4'd0, 1'b0},  // precharge r0 b0, 2 clocks later
    {2'd3, 1'b0, 2'd1, 4'd0, 1'b1},  // other bank free (R4)
    {2'd2, 1'b1, 2'd0, 4'd0, 1'b1},  // other rank free (R4)
    {2'd2, 1'b0, 2'd0, 4'd3, 1'b0},  // read at 8 of 9
    {2'd2, 1'b0, 2'd0, 4'd0, 1'b1},  // read at 9
    {2'd3, 1'b0, 2'd0, 4'd0, 1'b0},  // precharge at 10 of 11
    {2'd3, 1'b0, 2'd0, 4'd0, 1'b1},  // precharge at 11
    {2'd1, 1'b1, 2'd2, 4'd0, 1'b1},  // write r1 b2
    {2'd1, 1'b1, 2'd2, 4'd5, 1'b1},  // rewrite after 6 (R5)
    {2'd2, 1'b1, 2'd0, 4'd5, 1'b0},  // read 6 after rewrite
    {2'd3, 1'b1, 2'd2, 4'd3, 1'b0},  // precharge 10 after rewrite
    {2'd3, 1'b1, 2'd2, 4'd0, 1'b1},  // precharge 11 after rewrite
    {2'd2, 1'b1, 2'd0, 4'd0, 1'b1}   // read 12 after rewrite
  };

  function automatic string vec_tag(input int k);
    case (k)
      0, 9:            return "R1";
      3, 4:            return "R4";
      10, 11, 12, 13:  return "R5";
      1, 5, 6, 14:     return "R3";
      default:         return "R2";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit g;
    do_reset();
    // reset state: quiet, no error, timers open
    cmd(2'b00, 0, 0, "R1");
    cmd(2'b10, 0, 0, "R3");
    cmd(2'b11, 1, 3, "R2");

    // vector table, default gaps 11 / 9 (R6)
    do_reset();
    for (int k = 0; k < 15; k++) begin
      idle(int'(VEC[k][4:1]), vec_tag(k));
      step(VEC[k][9:8], int'(VEC[k][7]), int'(VEC[k][6:5]), 1'b0, 8'h00, vec_tag(k), g);
      check(g == VEC[k][0], vec_tag(k), "table grant", g, VEC[k][0]);
    end

    // smallest legal codes: precharge gap 4, read gap 6 (R6)
    do_reset();
    load_cfg(8'h46, "R6");
    cmd(2'b01, 0, 3, "R1");
    idle(3, "R6");
    cmd(2'b10, 0, 0, "R3");
    cmd(2'b11, 0, 3, "R6");
    cmd(2'b10, 0, 0, "R6");

    // reserved read code 0xD: flag set, read gap pinned at 12 (R7, R8)
    load_cfg(8'h4D, "R7");
    cmd(2'b01, 1, 0, "R1");
    idle(10, "R8");
    cmd(2'b10, 1, 0, "R8");
    cmd(2'b10, 1, 0, "R8");
    // later legal code keeps flag and ceiling (R7, R8)
    load_cfg(8'h46, "R7");
    cmd(2'b01, 1, 0, "R1");
    idle(10, "R8");
    cmd(2'b10, 1, 0, "R8");
    cmd(2'b10, 1, 0, "R8");
    cmd(2'b11, 1, 0, "R2");

    // reserved precharge code 0x3: gap 15 (R8)
    load_cfg(8'h36, "R7");
    cmd(2'b01, 0, 1, "R1");
    idle(13, "R8");
    cmd(2'b11, 0, 1, "R8");
    cmd(2'b11, 0, 1, "R8");

    // legality edges (R7)
    do_reset();
    load_cfg(8'h4C, "R7");
    cmd(2'b00, 0, 0, "R7");
    load_cfg(8'h45, "R7");
    cmd(2'b00, 0, 0, "R7");
    do_reset();
    load_cfg(8'hFE, "R7");
    cmd(2'b00, 0, 0, "R7");
    do_reset();
    load_cfg(8'h36, "R7");
    cmd(2'b00, 0, 0, "R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule